// File: doc/BRIEF.md
# BCH Correction Applier

This block runs after a page has been read and a BCH decoder has produced its per-field reports. It walks the decoder's status words. For every field that has a correctable result, it fetches the error locations and XOR patterns for that field. Each location falls into one of three regions: the field's user data, the three protected bytes at the head of the spare area, or the field's parity bytes inside the spare area. The block repairs the matching byte through a read-modify-write memory port. It adds up the error counts and reports the sum as the corrected total. If a field cannot be corrected, the walk stops at once and a failure flag is raised.

A host sets the correction mode, the field count and the spare-area size, then pulses `start`. The block reads report words through a small indexed port with combinational data. It ends the walk with a one-cycle `done` pulse. After that pulse, `fail` and `corr_total` keep their values until the next start.

Top module: `bch_fix_engine`

## Requirements
- R1: After reset, `done`, `fail`, `corr_total`, `mem_rd` and `mem_wr` are all 0. A `start` pulse clears `fail` and `corr_total`. Every walk ends with `done` high for exactly one cycle. `fail` and `corr_total` then hold their values until the next `start`.
- R2: Field f is described by byte f mod 4 of status word f/4. In that byte, bits 1:0 equal to 0 mean no error, 1 means correctable, and 2 or 3 mean uncorrectable.
- R3: The block reads ceil(n_fields/4) status words. A status word equal to zero is skipped and causes no memory access.
- R4: For a correctable field, bits 6:2 of its status byte give its error count. `corr_total` is the sum of these counts over the correctable fields that were visited.
- R5: Error k of the current field has its 11-bit location in address word k/2. The location sits in bits 10:0 when k is even and in bits 26:16 when k is odd.
- R6: The XOR pattern of error k is byte k mod 4 of pattern word k/4, with byte 0 in bits 7:0.
- R7: A location L below the field size F is a data error. The block reads the data byte at F × field index + L, XORs the pattern into it and writes it back. Data accesses use bits 7:0 of the memory data.
- R8: A location L with F ≤ L < F+3 is a protected spare error. The pattern is XORed into byte lane L−F of spare word 0.
- R9: Any other location is a parity error. Its spare byte position is spare_bytes − P × n_fields + P × field index + (L − (F + pad − P)). The block corrects spare word position/4 at byte lane position mod 4.
- R10: `mode` selects the geometry as (F, P, pad). Value 0 gives (512, 15, 32), value 1 gives (512, 23, 32), and values 2 and 3 give (1024, 45, 64).
- R11: An uncorrectable field ends the walk at once and sets `fail`. No later field is corrected. `corr_total` then holds the sum of the fields that came before it.
- R12: Every correction is a read (`mem_rd`) followed in the next cycle by a write (`mem_wr`) to the same address and area. Read data arrives one cycle after the read. `mem_spare` selects spare words over data bytes. No access is made while the block is idle.
- R13: Status bytes for field indices at or above `n_fields` in the last status word are ignored, even when they are marked uncorrectable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a correction walk |
| mode | input | 2 | Geometry select: 0, 1, 2/3 |
| n_fields | input | 5 | Number of ECC fields in the page |
| spare_bytes | input | 10 | Size of the spare area in bytes |
| rep_kind | output | 2 | Report bank: 0 status, 1 locations, 2 patterns |
| rep_field | output | 4 | Field whose locations or patterns are read |
| rep_idx | output | 4 | Word index inside the selected bank |
| rep_rdata | input | 32 | Report word (combinational) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_spare | output | 1 | 1: spare word access, 0: data byte access |
| mem_addr | output | 16 | Data byte address or spare word index |
| mem_wdata | output | 32 | Corrected write data |
| mem_rdata | input | 32 | Read data, one cycle after `mem_rd` |
| done | output | 1 | One-cycle end-of-walk pulse |
| fail | output | 1 | An uncorrectable field was met |
| corr_total | output | 9 | Sum of corrected error counts |

## Verification
The bench targets the region boundaries: L = F−1, F, F+2, the first parity byte F+pad−P and the last parity byte F+pad−1. An off-by-one at any of these would corrupt a neighbouring data byte or the wrong spare lane. It runs all-zero and partly zero status pages; a design that did not skip these would issue memory accesses or mis-step its groups. It places an uncorrectable field in the middle of a page with errors after it, and marks unused lanes beyond `n_fields` as uncorrectable. A design that kept going or decoded the unused lanes would change later bytes or raise `fail` falsely. Mode 3 is exercised to confirm it aliases to the 1024-byte geometry.

// File: rtl/bch_fix_pkg.sv
package bch_fix_pkg;

  localparam int POS_W = 16;

  typedef enum logic [1:0] {
    REP_STATUS = 2'd0,
    REP_LOC    = 2'd1,
    REP_PAT    = 2'd2
  } rep_kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_STAT, S_LANE, S_EA, S_ED, S_RD, S_WR, S_DONE
  } fix_state_e;

  // Target of one correction: area, address and byte lane
  typedef struct packed {
    logic             spare;
    logic [POS_W-1:0] addr;
    logic [1:0]       lane;
  } fix_tgt_t;

  function automatic int field_bytes(input logic [1:0] mode);
    return (mode[1]) ? 1024 : 512;
  endfunction

  function automatic int parity_bytes(input logic [1:0] mode);
    case (mode)
      2'd0:    return 15;
      2'd1:    return 23;
      default: return 45;
    endcase
  endfunction

  function automatic int pad_bytes(input logic [1:0] mode);
    return (mode[1]) ? 64 : 32;
  endfunction

  function automatic logic [1:0] stat_state(input logic [31:0] w, input logic [1:0] lane);
    return w[8*lane +: 2];
  endfunction

  function automatic logic [4:0] stat_count(input logic [31:0] w, input logic [1:0] lane);
    return w[8*lane+2 +: 5];
  endfunction

  function automatic logic [10:0] loc_pick(input logic [31:0] w, input logic odd);
    return odd ? w[26:16] : w[10:0];
  endfunction

  function automatic logic [7:0] pat_pick(input logic [31:0] w, input logic [1:0] k);
    return w[8*k +: 8];
  endfunction

  // Region classification and address arithmetic for one error location
  function automatic fix_tgt_t locate_err(input logic [1:0] mode, input logic [10:0] loc,
                                          input logic [7:0] fidx, input logic [15:0] spare,
                                          input logic [7:0] nf);
    fix_tgt_t t;
    int fsz, par, pad, l, pos;
    fsz = field_bytes(mode);
    par = parity_bytes(mode);
    pad = pad_bytes(mode);
    l   = int'(loc);
    t   = '0;
    if (l < fsz) begin
      t.spare = 1'b0;
      t.addr  = POS_W'(int'(fidx) * fsz + l);
    end else if (l < fsz + 3) begin
      t.spare = 1'b1;
      t.lane  = 2'(l - fsz);
    end else begin
      pos = int'(spare) - par * int'(nf) + par * int'(fidx) + l - (fsz + pad - par);
      t.spare = 1'b1;
      t.addr  = POS_W'(pos >>> 2);
      t.lane  = 2'(pos);
    end
    return t;
  endfunction

endpackage

// File: rtl/bch_fix_unpack.sv
module bch_fix_unpack (
  input  logic [31:0] stat_word,
  input  logic [1:0]  lane,
  input  logic [31:0] rep_word,
  input  logic [1:0]  eidx_lo,
  output logic [1:0]  st,
  output logic [4:0]  cnt,
  output logic [10:0] loc,
  output logic [7:0]  pat
);
  import bch_fix_pkg::*;

  assign st  = stat_state(stat_word, lane);
  assign cnt = stat_count(stat_word, lane);
  assign loc = loc_pick(rep_word, eidx_lo[0]);
  assign pat = pat_pick(rep_word, eidx_lo);
endmodule

// File: rtl/bch_fix_locate.sv
module bch_fix_locate #(
  parameter int FW  = 5,
  parameter int FIW = 4,
  parameter int SW  = 10
) (
  input  logic [1:0]           mode,
  input  logic [10:0]          loc,
  input  logic [FIW-1:0]       fidx,
  input  logic [SW-1:0]        spare,
  input  logic [FW-1:0]        nf,
  output bch_fix_pkg::fix_tgt_t tgt
);
  import bch_fix_pkg::*;

  assign tgt = locate_err(mode, loc, 8'(fidx), 16'(spare), 8'(nf));
endmodule

// File: rtl/bch_fix_seq.sv
module bch_fix_seq #(
  parameter int MAX_ERR = 24,
  parameter int ADDR_W  = 16,
  parameter int FW      = 5,
  parameter int FIW     = 4,
  parameter int SW      = 10,
  parameter int IW      = 4,
  parameter int TW      = 9
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [1:0]             mode_i,
  input  logic [FW-1:0]          nf_i,
  input  logic [SW-1:0]          spare_i,
  input  logic [31:0]            rep_rdata,
  input  logic [1:0]             st,
  input  logic [4:0]             cnt,
  input  logic [10:0]            loc,
  input  logic [7:0]             pat,
  input  bch_fix_pkg::fix_tgt_t  tgt,
  input  logic [31:0]            mem_rdata,
  output logic [31:0]            stat_q,
  output logic [1:0]             lane_q,
  output logic [1:0]             eidx_lo,
  output logic [10:0]            loc_q,
  output logic [FIW-1:0]         fidx,
  output logic [1:0]             mode_q,
  output logic [FW-1:0]          nf_q,
  output logic [SW-1:0]          spare_q,
  output logic [1:0]             rep_kind,
  output logic [FIW-1:0]         rep_field,
  output logic [IW-1:0]          rep_idx,
  output logic                   mem_rd,
  output logic                   mem_wr,
  output logic                   mem_spare,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic [31:0]            mem_wdata,
  output logic                   busy,
  output logic                   done,
  output logic                   fail,
  output logic [TW-1:0]          corr_total
);
  import bch_fix_pkg::*;

  localparam int GW = FIW - 2;

  fix_state_e       state_q, adv_state;
  logic [GW-1:0]    grp_q, adv_grp;
  logic [1:0]       adv_lane;
  logic [4:0]       eidx_q, lim_q;
  logic [7:0]       pat_q;
  fix_tgt_t         tgt_q;
  logic [TW-1:0]    total_q;
  logic             fail_q;
  logic [FW-1:0]    ngroups;
  logic             last_grp, last_lane, fld_out;
  logic             err_last;

  assign fidx      = {grp_q, lane_q};
  assign ngroups   = (nf_q + FW'(3)) >> 2;
  assign last_grp  = (FW'(grp_q) + FW'(1)) >= ngroups;
  assign last_lane = (lane_q == 2'd3) || ((FW'(fidx) + FW'(1)) >= nf_q);
  assign fld_out   = FW'(fidx) >= nf_q;
  assign err_last  = (eidx_q + 5'd1) == lim_q;
  assign eidx_lo   = eidx_q[1:0];

  // Step to the next field lane, next status word or the end of the walk
  always_comb begin
    adv_state = S_LANE;
    adv_grp   = grp_q;
    adv_lane  = lane_q + 2'd1;
    if (last_lane) begin
      adv_lane = 2'd0;
      if (last_grp) begin
        adv_state = S_DONE;
      end else begin
        adv_state = S_STAT;
        adv_grp   = grp_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      grp_q   <= '0;
      lane_q  <= '0;
      stat_q  <= '0;
      eidx_q  <= '0;
      lim_q   <= '0;
      loc_q   <= '0;
      pat_q   <= '0;
      tgt_q   <= '0;
      total_q <= '0;
      fail_q  <= 1'b0;
      mode_q  <= '0;
      nf_q    <= '0;
      spare_q <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (start) begin
          mode_q  <= mode_i;
          nf_q    <= nf_i;
          spare_q <= spare_i;
          grp_q   <= '0;
          lane_q  <= '0;
          total_q <= '0;
          fail_q  <= 1'b0;
          state_q <= S_STAT;
        end
        S_STAT: begin
          if (rep_rdata == 32'd0) begin
            if (last_grp) state_q <= S_DONE;
            else grp_q <= grp_q + 1'b1;
          end else begin
            stat_q  <= rep_rdata;
            lane_q  <= 2'd0;
            state_q <= S_LANE;
          end
        end
        S_LANE: begin
          if (fld_out || st == 2'd0 || (st == 2'd1 && cnt == 5'd0)) begin
            state_q <= adv_state;
            grp_q   <= adv_grp;
            lane_q  <= adv_lane;
          end else if (st == 2'd1) begin
            total_q <= total_q + TW'(cnt);
            eidx_q  <= '0;
            lim_q   <= (int'(cnt) > MAX_ERR) ? 5'(MAX_ERR) : cnt;
            state_q <= S_EA;
          end else begin
            fail_q  <= 1'b1;
            state_q <= S_DONE;
          end
        end
        S_EA: begin
          loc_q   <= loc;
          state_q <= S_ED;
        end
        S_ED: begin
          pat_q   <= pat;
          tgt_q   <= tgt;
          state_q <= S_RD;
        end
        S_RD: state_q <= S_WR;
        S_WR: begin
          eidx_q <= eidx_q + 5'd1;
          if (err_last) begin
            state_q <= adv_state;
            grp_q   <= adv_grp;
            lane_q  <= adv_lane;
          end else begin
            state_q <= S_EA;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    rep_kind  = REP_STATUS;
    rep_field = '0;
    rep_idx   = IW'(grp_q);
    case (state_q)
      S_EA: begin
        rep_kind  = REP_LOC;
        rep_field = fidx;
        rep_idx   = IW'(eidx_q >> 1);
      end
      S_ED: begin
        rep_kind  = REP_PAT;
        rep_field = fidx;
        rep_idx   = IW'(eidx_q >> 2);
      end
      default: ;
    endcase
  end

  assign mem_rd     = (state_q == S_RD);
  assign mem_wr     = (state_q == S_WR);
  assign mem_spare  = (mem_rd || mem_wr) && tgt_q.spare;
  assign mem_addr   = (mem_rd || mem_wr) ? tgt_q.addr[ADDR_W-1:0] : '0;
  assign mem_wdata  = mem_wr ? (mem_rdata ^ ({24'd0, pat_q} << (8 * tgt_q.lane))) : 32'd0;
  assign busy       = (state_q != S_IDLE);
  assign done       = (state_q == S_DONE);
  assign fail       = fail_q;
  assign corr_total = total_q;
endmodule

// File: rtl/bch_fix_engine.sv
module bch_fix_engine #(
  parameter int MAX_FIELDS = 16,
  parameter int MAX_ERR    = 24,
  parameter int ADDR_W     = 16,
  parameter int SW         = 10,
  localparam int FW  = $clog2(MAX_FIELDS + 1),
  localparam int FIW = $clog2(MAX_FIELDS),
  localparam int IW  = $clog2((MAX_ERR + 1) / 2),
  localparam int TW  = $clog2(MAX_FIELDS * 31 + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic [FW-1:0]     n_fields,
  input  logic [SW-1:0]     spare_bytes,
  output logic [1:0]        rep_kind,
  output logic [FIW-1:0]    rep_field,
  output logic [IW-1:0]     rep_idx,
  input  logic [31:0]       rep_rdata,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              mem_spare,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              done,
  output logic              fail,
  output logic [TW-1:0]     corr_total
);
  import bch_fix_pkg::*;

  logic [31:0]    stat_q;
  logic [1:0]     lane_q, eidx_lo, st, mode_q;
  logic [4:0]     cnt;
  logic [10:0]    loc, loc_q;
  logic [7:0]     pat;
  logic [FIW-1:0] fidx;
  logic [FW-1:0]  nf_q;
  logic [SW-1:0]  spare_q;
  fix_tgt_t       tgt;
  logic           busy;

  bch_fix_unpack unpack_i (
    .stat_word(stat_q), .lane(lane_q), .rep_word(rep_rdata), .eidx_lo(eidx_lo),
    .st(st), .cnt(cnt), .loc(loc), .pat(pat)
  );

  bch_fix_locate #(.FW(FW), .FIW(FIW), .SW(SW)) locate_i (
    .mode(mode_q), .loc(loc_q), .fidx(fidx), .spare(spare_q), .nf(nf_q), .tgt(tgt)
  );

  bch_fix_seq #(
    .MAX_ERR(MAX_ERR), .ADDR_W(ADDR_W), .FW(FW), .FIW(FIW), .SW(SW), .IW(IW), .TW(TW)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_i(mode), .nf_i(n_fields),
    .spare_i(spare_bytes), .rep_rdata(rep_rdata), .st(st), .cnt(cnt), .loc(loc),
    .pat(pat), .tgt(tgt), .mem_rdata(mem_rdata), .stat_q(stat_q), .lane_q(lane_q),
    .eidx_lo(eidx_lo), .loc_q(loc_q), .fidx(fidx), .mode_q(mode_q), .nf_q(nf_q),
    .spare_q(spare_q), .rep_kind(rep_kind), .rep_field(rep_field), .rep_idx(rep_idx),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_spare(mem_spare), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .busy(busy), .done(done), .fail(fail), .corr_total(corr_total)
  );
endmodule

// File: rtl/bch_fix_check.sv
module bch_fix_check #(
  parameter int ADDR_W = 16,
  parameter int TW     = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              fail,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              mem_spare,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [TW-1:0]     corr_total
);
  p_quiet_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd && !mem_wr));

  p_rmw_pair_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> (mem_wr && $stable(mem_addr) && $stable(mem_spare)));

  p_wr_after_rd_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(mem_rd));

  p_one_op_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_fail_at_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> done);

  p_hold_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(corr_total) && $stable(fail)));
endmodule

bind bch_fix_engine bch_fix_check #(.ADDR_W(ADDR_W), .TW(TW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .fail(fail),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_spare(mem_spare), .mem_addr(mem_addr),
  .corr_total(corr_total)
);

// File: tb/bch_fix_engine_tb_top.sv
module bch_fix_engine_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [4:0]  n_fields = 5'd1;
  logic [9:0]  spare_bytes = 10'd0;
  logic [1:0]  rep_kind;
  logic [3:0]  rep_field;
  logic [3:0]  rep_idx;
  logic [31:0] rep_rdata;
  logic        mem_rd, mem_wr, mem_spare;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = 32'd0;
  logic        done, fail;
  logic [8:0]  corr_total;

  always #10 clk = ~clk;

  bch_fix_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .n_fields(n_fields),
    .spare_bytes(spare_bytes), .rep_kind(rep_kind), .rep_field(rep_field),
    .rep_idx(rep_idx), .rep_rdata(rep_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_spare(mem_spare), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .done(done), .fail(fail), .corr_total(corr_total)
  );

  // Decoder report model
  logic [31:0] stat_w [4];
  logic [31:0] loc_w  [16][12];
  logic [31:0] pat_w  [16][6];

  always_comb begin
    case (rep_kind)
      2'd0:    rep_rdata = stat_w[rep_idx[1:0]];
      2'd1:    rep_rdata = (rep_idx < 12) ? loc_w[rep_field][rep_idx] : 32'd0;
      2'd2:    rep_rdata = (rep_idx < 6) ? pat_w[rep_field][rep_idx[2:0]] : 32'd0;
      default: rep_rdata = 32'd0;
    endcase
  end

  // Memory model: data bytes and spare words, one-cycle read latency
  logic [7:0]  dmem [8192];
  logic [31:0] smem [128];
  logic [7:0]  exp_d [8192];
  logic [7:0]  exp_s [512];
  int run_acc = 0;
  int idle_acc = 0;
  bit in_run = 1'b0;

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem_spare ? smem[mem_addr[6:0]] : {24'd0, dmem[mem_addr[12:0]]};
    if (mem_wr) begin
      if (mem_spare) smem[mem_addr[6:0]] <= mem_wdata;
      else dmem[mem_addr[12:0]] <= mem_wdata[7:0];
    end
    if (rst_n && (mem_rd || mem_wr)) begin
      if (in_run) run_acc <= run_acc + 1;
      else idle_acc <= idle_acc + 1;
    end
  end

  int checks = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic int g_fsz(input logic [1:0] m);
    return (m == 2'd0 || m == 2'd1) ? 512 : 1024;
  endfunction
  function automatic int g_par(input logic [1:0] m);
    return (m == 2'd0) ? 15 : (m == 2'd1) ? 23 : 45;
  endfunction
  function automatic int g_pad(input logic [1:0] m);
    return (m == 2'd0 || m == 2'd1) ? 32 : 64;
  endfunction

  task automatic clear_reports();
    for (int i = 0; i < 4; i++) stat_w[i] = 32'd0;
    for (int f = 0; f < 16; f++) begin
      for (int j = 0; j < 12; j++) loc_w[f][j] = 32'd0;
      for (int j = 0; j < 6; j++) pat_w[f][j] = 32'd0;
    end
  endtask

  task automatic put_stat(input int f, input int st, input int c);
    stat_w[f/4][(f%4)*8 +: 8] = {1'b0, 5'(c), 2'(st)};
  endtask

  task automatic put_err(input int f, input int k, input int a, input int p);
    loc_w[f][k/2][(k%2)*16 +: 11] = 11'(a);
    pat_w[f][k/4][(k%4)*8 +: 8] = 8'(p);
  endtask

  function automatic int rand_loc(input logic [1:0] m);
    int r;
    r = int'($urandom % 3);
    if (r == 0) return int'($urandom % 32'(g_fsz(m)));
    if (r == 1) return g_fsz(m) + int'($urandom % 3);
    return g_fsz(m) + g_pad(m) - g_par(m) + int'($urandom % 32'(g_par(m)));
  endfunction

  // Fill reports for a page; bad_f >= 0 marks that field uncorrectable
  task automatic gen_page(input logic [1:0] m, input int nf, input int bad_f);
    int c, st;
    clear_reports();
    for (int f = 0; f < nf; f++) begin
      c  = ($urandom % 4 == 0) ? int'($urandom % 25) : int'($urandom % 6);
      st = 1;
      if ($urandom % 5 == 0) begin st = 0; c = 0; end
      if (f == bad_f) begin st = 2 + int'($urandom % 2); c = 3; end
      put_stat(f, st, c);
      for (int k = 0; k < c; k++) put_err(f, k, rand_loc(m), 1 + int'($urandom % 255));
    end
  endtask

  // Independent expected-value model of the walk
  task automatic model(input logic [1:0] m, input int nf, input int spare,
                       output bit efail, output int etot);
    int fsz, par, pad, a, p, pos, c;
    logic [7:0] b;
    bit stop;
    fsz = g_fsz(m); par = g_par(m); pad = g_pad(m);
    efail = 1'b0; etot = 0; stop = 1'b0;
    for (int g = 0; g < (nf + 3) / 4 && !stop; g++) begin
      for (int l = 0; l < 4 && !stop; l++) begin
        int f;
        f = g * 4 + l;
        if (f < nf) begin
          b = stat_w[g][l*8 +: 8];
          if (b[1:0] == 2'd1) begin
            c = int'(b[6:2]);
            etot += c;
            for (int k = 0; k < c; k++) begin
              a = int'(loc_w[f][k/2][(k%2)*16 +: 11]);
              p = int'(pat_w[f][k/4][(k%4)*8 +: 8]);
              if (a < fsz) exp_d[f*fsz + a] ^= 8'(p);
              else if (a < fsz + 3) exp_s[a - fsz] ^= 8'(p);
              else begin
                pos = spare - par * nf + par * f + (a - (fsz + pad - par));
                exp_s[pos] ^= 8'(p);
              end
            end
          end else if (b[1:0] != 2'd0) begin
            efail = 1'b1;
            stop  = 1'b1;
          end
        end
      end
    end
  endtask

  task automatic run(input logic [1:0] m, input int nf, input string tag, input bit want_no_acc);
    int spare, etot, w, bad_d, bad_s;
    bit efail;
    spare = ((g_par(m) * nf + 3) / 4) * 4 + 8;
    for (int i = 0; i < 8192; i++) begin dmem[i] = 8'($urandom); exp_d[i] = dmem[i]; end
    for (int i = 0; i < 128; i++) begin
      smem[i] = $urandom;
      for (int j = 0; j < 4; j++) exp_s[i*4 + j] = smem[i][j*8 +: 8];
    end
    model(m, nf, spare, efail, etot);
    @(negedge clk);
    mode = m; n_fields = 5'(nf); spare_bytes = 10'(spare);
    in_run = 1'b1; run_acc = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    w = 0;
    while (!done && w < 20000) begin @(negedge clk); w++; end
    chk(done == 1'b1, "R1", {tag, " done pulse"}, int'(done), 1);
    chk(fail == efail, "R2 R11", {tag, " fail flag"}, int'(fail), int'(efail));
    chk(int'(corr_total) == etot, "R4", {tag, " corrected total"}, int'(corr_total), etot);
    @(negedge clk);
    chk(done == 1'b0, "R1", {tag, " done is one cycle"}, int'(done), 0);
    chk(int'(corr_total) == etot, "R1", {tag, " total held"}, int'(corr_total), etot);
    in_run = 1'b0;
    bad_d = 0; bad_s = 0;
    for (int i = 0; i < 8192; i++) if (dmem[i] !== exp_d[i]) bad_d++;
    for (int i = 0; i < 512; i++) if (smem[i/4][(i%4)*8 +: 8] !== exp_s[i]) bad_s++;
    chk(bad_d == 0, "R5 R6 R7 R10", {tag, " data bytes wrong"}, bad_d, 0);
    chk(bad_s == 0, "R8 R9 R10", {tag, " spare bytes wrong"}, bad_s, 0);
    if (want_no_acc) chk(run_acc == 0, "R3", {tag, " accesses on zero status"}, run_acc, 0);
  endtask

  // Boundary locations in one field, all regions
  task automatic edge_page(input logic [1:0] m, input int nf);
    int f, fsz, par, pad;
    fsz = g_fsz(m); par = g_par(m); pad = g_pad(m);
    f = nf - 1;
    clear_reports();
    put_stat(0, 1, 1);
    put_err(0, 0, 0, 8'h5A);
    put_stat(f, 1, 6);
    put_err(f, 0, fsz - 1, 8'h81);
    put_err(f, 1, fsz, 8'h42);
    put_err(f, 2, fsz + 2, 8'h24);
    put_err(f, 3, fsz + pad - par, 8'h18);
    put_err(f, 4, fsz + pad - 1, 8'hFF);
    put_err(f, 5, fsz + 1, 8'h01);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240923));
    clear_reports();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk(done == 1'b0 && fail == 1'b0, "R1", "reset done/fail", int'({done, fail}), 0);
    chk(corr_total == 9'd0, "R1", "reset total", int'(corr_total), 0);
    chk(!mem_rd && !mem_wr, "R1", "reset memory strobes", int'({mem_rd, mem_wr}), 0);

    // R3: every status word zero, junk in the other banks
    clear_reports();
    put_err(0, 0, 5, 8'h33);
    run(2'd0, 4, "zero-status", 1'b1);

    // R7 R8 R9 R10: boundary locations in every mode, mode 3 aliases T24
    edge_page(2'd0, 4);  run(2'd0, 4, "edges-m0", 1'b0);
    edge_page(2'd1, 8);  run(2'd1, 8, "edges-m1", 1'b0);
    edge_page(2'd2, 2);  run(2'd2, 2, "edges-m2", 1'b0);
    edge_page(2'd3, 4);  run(2'd3, 4, "edges-m3", 1'b0);

    // R13: unused lanes beyond n_fields marked uncorrectable
    edge_page(2'd2, 2);
    put_stat(2, 2, 0);
    put_stat(3, 3, 0);
    run(2'd2, 2, "R13 unused-lanes", 1'b0);

    // R11: uncorrectable mid page, code 2, then code 3 at field 0
    gen_page(2'd0, 8, 5);
    put_stat(6, 1, 2); put_err(6, 0, 10, 8'h77); put_err(6, 1, 520, 8'h11);
    run(2'd0, 8, "R11 fail-mid", 1'b0);
    gen_page(2'd1, 4, 0);
    put_stat(0, 3, 0);
    run(2'd1, 4, "R11 fail-first", 1'b0);

    // R3: zero status word in the middle of a 16-field page
    gen_page(2'd0, 16, -1);
    stat_w[1] = 32'd0;
    run(2'd0, 16, "R3 skip-group", 1'b0);

    // R4: correctable state with a zero count
    edge_page(2'd0, 4);
    put_stat(1, 1, 0);
    put_err(1, 0, 7, 8'h99);
    run(2'd0, 4, "R4 zero-count", 1'b0);

    // Random pages, some with an uncorrectable field
    for (int r = 0; r < 30; r++) begin
      logic [1:0] m;
      int nf, sel;
      m   = 2'($urandom % 4);
      sel = int'($urandom % 3);
      if (m[1]) nf = (sel == 0) ? 2 : (sel == 1) ? 4 : 8;
      else      nf = (sel == 0) ? 4 : (sel == 1) ? 8 : 16;
      if ($urandom % 8 == 0) nf = 1;
      gen_page(m, nf, ($urandom % 5 == 0) ? int'($urandom % 32'(nf)) : -1);
      run(m, nf, "random", 1'b0);
    end

    repeat (5) @(negedge clk);
    // R12: nothing touched memory while idle
    chk(idle_acc == 0, "R12", "idle accesses", idle_acc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule